// File: doc/BRIEF.md
# Mix Cancel and Edge Synchronizer

This block sits behind a serial receiver that delivers 40-bit parallel words. An external mixer has combined the wanted input with a known low-frequency square pattern, so the receiver sees a stream with enough transitions even when the input itself is idle for long runs. The block takes the received word and the matching reference word of the mix pattern in the same cycle. Once aligned, it removes the pattern by XOR and returns a digitized copy of the original input.

Alignment is found by pulsing a slip output that shifts the receiver's word boundary by one bit. After each slip the block waits a fixed settle time and then compares again. The input must stay low during this hunt. After a reference edge word matches exactly, the block reports lock. It then follows the pattern edges and tolerates a drift of a few bit times. It declares loss only after a long unbroken run of missed edges. Loss either starts a new hunt automatically or parks the block until enable is cycled.

Top module: `mix_cancel_sync`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are zero after that edge: `data_out`, `slip`, `locked` and `lock_lost`.
- R2: While `enable` is low, `slip`, `locked` and `lock_lost` stay at zero whatever the received data.
- R3: `slip` is a pulse one clock wide. Two pulses are at least SLIP_WAIT+1 (default 9) clocks apart.
- R4: Bit 0 of each word is the first bit received. A reference edge word is a word in which `mix_ref` differs between two neighbouring bits, where the bit before bit 0 is bit 39 of the previous word. While hunting, a reference edge word with `rx_word` different from `mix_ref` produces a slip. When the two are equal, the block locks. Starting from a receiver offset of k bits with idle input, exactly k slips occur before `locked` rises, and `slip` is never high while `locked` is high.
- R5: While locked, `data_out` equals `rx_word ^ mix_ref` of the previous clock.
- R6: While not locked, `data_out` is zero one clock later.
- R7: Let p be the first transition position of the reference word. An edge counts as seen when `rx_word` has a transition at some position in p-4..p+4. A steady offset of +4 or -4 bits therefore keeps `locked` high with `lock_lost` low.
- R8: Each unseen edge in a reference edge word adds to a miss count. `lock_lost` rises at the edge that follows the clock of the 61st consecutive missed edge (more than 30 mix periods), and `locked` falls at the same edge.
- R9: With `auto_reacq` high, `lock_lost` is high for exactly one clock and hunting restarts by itself.
- R10: With `auto_reacq` low, `lock_lost` stays high with no slips until `enable` goes low. After `enable` returns high, a new hunt runs.
- R11: Any seen edge clears the miss count, so two runs of 60 missed edges separated by one seen edge cause no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the block; low returns it to idle |
| auto_reacq | input | 1 | High: a loss of lock restarts the hunt by itself |
| rx_word | input | 40 | Word from the receiver, bit 0 first |
| mix_ref | input | 40 | Reference mix pattern word for the same cycle |
| data_out | output | 40 | Received word with the mix removed, zero when not locked |
| slip | output | 1 | One-clock request to shift the receiver word boundary by one bit |
| locked | output | 1 | Alignment found and held |
| lock_lost | output | 1 | Too many consecutive edges missed |

## Verification
`data_out` is registered, so it is due one clock after the word that produced it. The bench records `locked` when it drives a word and compares `data_out` just after the next edge. A slip appears one clock after the mismatching edge word, and the receiver model applies the shift to the word after that sample. `lock_lost` is due one clock after the 61st missed edge word. The bench counts edge words by their known position in the pattern, checks the flag on every edge word, and checks the single-clock pulse on the clock after it. All samples are taken 1 ns after the rising edge.

// File: rtl/acb_pkg.sv
package acb_pkg;

    // Defaults shared by the block and its bench
    localparam int ACB_WORD_W    = 40;
    localparam int ACB_DRIFT     = 4;
    localparam int ACB_SLIP_WAIT = 8;
    localparam int ACB_LOSS_PER  = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SETTLE,
        ST_LOCKED,
        ST_HALTED
    } acb_state_e;

    // Per-word evaluation passed from the edge stage to the control stages
    typedef struct packed {
        logic ref_edge;   // reference word holds a transition
        logic seen;       // received transition within the drift window
        logic match;      // received word equals reference word
    } acb_eval_t;

    // Twice the loss period count: two edges per mix period
    function automatic int loss_edges(input int periods);
        return 2 * periods;
    endfunction

endpackage

// File: rtl/acb_edge_eval.sv
module acb_edge_eval
    import acb_pkg::*;
#(
    parameter int W     = ACB_WORD_W,
    parameter int DRIFT = ACB_DRIFT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rx_word,
    input  logic [W-1:0] mix_ref,
    output acb_eval_t    eval
);
    localparam int PW = $clog2(W);

    logic         prev_rx;
    logic         prev_ref;
    logic [W-1:0] tr_rx;
    logic [W-1:0] tr_ref;
    logic [W-1:0] window;
    logic [PW-1:0] pos_ref;

    // Last bit of each word is the neighbour of bit 0 of the next
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rx  <= 1'b0;
            prev_ref <= 1'b0;
        end else begin
            prev_rx  <= rx_word[W-1];
            prev_ref <= mix_ref[W-1];
        end
    end

    assign tr_rx  = rx_word ^ {rx_word[W-2:0], prev_rx};
    assign tr_ref = mix_ref ^ {mix_ref[W-2:0], prev_ref};

    // First reference transition position
    always_comb begin
        pos_ref = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (tr_ref[i]) pos_ref = PW'(i);
        end
    end

    generate
        for (genvar g = 0; g < W; g++) begin : g_win
            assign window[g] = ((g + DRIFT) >= int'(pos_ref)) &&
                               (g <= (int'(pos_ref) + DRIFT));
        end
    endgenerate

    assign eval.ref_edge = |tr_ref;
    assign eval.seen     = (|tr_ref) && (|(tr_rx & window));
    assign eval.match    = (rx_word == mix_ref);

endmodule

// File: rtl/acb_loss_mon.sv
module acb_loss_mon
    import acb_pkg::*;
#(
    parameter int LOSS_PER = ACB_LOSS_PER
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      locked,
    input  acb_eval_t eval,
    output logic      loss
);
    localparam int LOSS_EDGES = loss_edges(LOSS_PER);
    localparam int MW         = $clog2(LOSS_EDGES + 1);

    logic [MW-1:0] miss_cnt;

    assign loss = locked && eval.ref_edge && !eval.seen &&
                  (miss_cnt == MW'(LOSS_EDGES));

    always_ff @(posedge clk) begin
        if (rst || !locked) begin
            miss_cnt <= '0;
        end else if (eval.ref_edge) begin
            if (eval.seen)
                miss_cnt <= '0;
            else if (miss_cnt != MW'(LOSS_EDGES))
                miss_cnt <= miss_cnt + 1'b1;
        end
    end

    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
        miss_cnt <= MW'(LOSS_EDGES)); // R8
    AST_SEEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (locked && eval.seen) |=> (miss_cnt == '0)); // R11

endmodule

// File: rtl/acb_sync_fsm.sv
module acb_sync_fsm
    import acb_pkg::*;
#(
    parameter int SLIP_WAIT = ACB_SLIP_WAIT
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      auto_reacq,
    input  acb_eval_t eval,
    input  logic      loss,
    output logic      locked,
    output logic      slip,
    output logic      lock_lost
);
    localparam int CW = $clog2(SLIP_WAIT + 1);

    acb_state_e    state;
    logic [CW-1:0] wait_cnt;

    assign locked = (state == ST_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            slip      <= 1'b0;
            lock_lost <= 1'b0;
            wait_cnt  <= '0;
        end else begin
            slip <= 1'b0;
            if (!enable) begin
                state     <= ST_IDLE;
                lock_lost <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE:   state <= ST_HUNT;
                    ST_HUNT: begin
                        if (eval.ref_edge) begin
                            if (eval.match) begin
                                state <= ST_LOCKED;
                            end else begin
                                slip     <= 1'b1;
                                wait_cnt <= '0;
                                state    <= ST_SETTLE;
                            end
                        end
                    end
                    ST_SETTLE: begin
                        if (wait_cnt == CW'(SLIP_WAIT - 1))
                            state <= ST_HUNT;
                        else
                            wait_cnt <= wait_cnt + 1'b1;
                    end
                    ST_LOCKED: begin
                        if (loss) state <= auto_reacq ? ST_HUNT : ST_HALTED;
                    end
                    ST_HALTED: state <= ST_HALTED;
                    default:   state <= ST_IDLE;
                endcase
                if (loss)
                    lock_lost <= 1'b1;
                else if (state != ST_HALTED)
                    lock_lost <= 1'b0;
            end
        end
    end

    AST_SLIP_PULSE: assert property (@(posedge clk) disable iff (rst)
        slip |=> !slip); // R3
    AST_SLIP_SETTLES: assert property (@(posedge clk) disable iff (rst)
        (slip && enable) |-> (state == ST_SETTLE)); // R3
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALTED && enable) |=> (lock_lost && !slip)); // R10

endmodule

// File: rtl/acb_cancel.sv
module acb_cancel
    import acb_pkg::*;
#(
    parameter int W = ACB_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         locked,
    input  logic [W-1:0] rx_word,
    input  logic [W-1:0] mix_ref,
    output logic [W-1:0] data_out
);
    always_ff @(posedge clk) begin
        if (rst)
            data_out <= '0;
        else if (locked)
            data_out <= rx_word ^ mix_ref;
        else
            data_out <= '0;
    end

endmodule

// File: rtl/mix_cancel_sync.sv
module mix_cancel_sync
    import acb_pkg::*;
#(
    parameter int W         = ACB_WORD_W,
    parameter int DRIFT     = ACB_DRIFT,
    parameter int SLIP_WAIT = ACB_SLIP_WAIT,
    parameter int LOSS_PER  = ACB_LOSS_PER
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         auto_reacq,
    input  logic [W-1:0] rx_word,
    input  logic [W-1:0] mix_ref,
    output logic [W-1:0] data_out,
    output logic         slip,
    output logic         locked,
    output logic         lock_lost
);
    acb_eval_t eval;
    logic      loss;

    acb_edge_eval #(.W(W), .DRIFT(DRIFT)) i_edge (
        .clk     (clk),
        .rst     (rst),
        .rx_word (rx_word),
        .mix_ref (mix_ref),
        .eval    (eval)
    );

    acb_loss_mon #(.LOSS_PER(LOSS_PER)) i_loss (
        .clk    (clk),
        .rst    (rst),
        .locked (locked),
        .eval   (eval),
        .loss   (loss)
    );

    acb_sync_fsm #(.SLIP_WAIT(SLIP_WAIT)) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .auto_reacq (auto_reacq),
        .eval       (eval),
        .loss       (loss),
        .locked     (locked),
        .slip       (slip),
        .lock_lost  (lock_lost)
    );

    acb_cancel #(.W(W)) i_cancel (
        .clk      (clk),
        .rst      (rst),
        .locked   (locked),
        .rx_word  (rx_word),
        .mix_ref  (mix_ref),
        .data_out (data_out)
    );

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!locked && !slip && !lock_lost)); // R2
    AST_LOCK_NO_SLIP: assert property (@(posedge clk) disable iff (rst)
        locked |-> !slip); // R4
    AST_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !locked |=> (data_out == '0)); // R6
    AST_LOST_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock_lost |-> !locked); // R8
    AST_REACQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        (lock_lost && auto_reacq && enable && $stable(auto_reacq)) |=> !lock_lost); // R9

endmodule

// File: tb/test_mix_cancel_sync.sv
`timescale 1ns/1ps
module test_mix_cancel_sync;
    localparam int W     = 40;
    localparam int SW    = 8;
    localparam int HALF  = 200;   // mix half period in bits
    localparam int PHASE = 180;   // puts every mix edge at bit 20
    localparam int EDGE_WORDS = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enable = 1'b0;
    logic         auto_reacq = 1'b1;
    logic [W-1:0] rx_word = '0;
    logic [W-1:0] mix_ref = '0;
    logic [W-1:0] data_out;
    logic         slip, locked, lock_lost;

    int checks = 0, fails = 0;
    int w = 0, cyc = 0, d = 0, slips = 0, last_slip = -100;
    int cur_w = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mix_cancel_sync i_mix_cancel_sync (
        .clk(clk), .rst(rst), .enable(enable), .auto_reacq(auto_reacq),
        .rx_word(rx_word), .mix_ref(mix_ref), .data_out(data_out),
        .slip(slip), .locked(locked), .lock_lost(lock_lost)
    );

    function automatic logic mixb(input int n);
        if (n < 0) return 1'b0;
        return (((n + PHASE) / HALF) % 2) != 0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic [W-1:0] data);
        logic         pre_lock;
        logic [W-1:0] rv, fv;
        @(negedge clk);
        pre_lock = locked;
        for (int i = 0; i < W; i++) begin
            fv[i] = mixb(W * w + i);
            rv[i] = mixb(W * w + i - d) ^ data[i];
        end
        mix_ref = fv;
        rx_word = rv;
        cur_w   = w;
        @(posedge clk);
        #1;
        w++;
        cyc++;
        if (pre_lock) chk("R5 data", 64'(data_out), 64'(rv ^ fv));
        else          chk("R6 zero", 64'(data_out), 64'd0);
        if (slip) begin
            if (cyc - last_slip < SW + 1) chk("R3 spacing", 64'(cyc - last_slip), 64'(SW + 1));
            last_slip = cyc;
            slips++;
            d = d - 1;
        end
    endtask

    task automatic acquire(output int n);
        int s0;
        s0 = slips;
        for (int k = 0; k < 4000 && !locked; k++) tick('0);
        n = slips - s0;
    endtask

    task automatic run_edges(input int n);
        int e;
        e = 0;
        while (e < n) begin
            tick('0);
            if (cur_w % EDGE_WORDS == 0) e++;
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int d0, n, e;
        logic [W-1:0] r;
        void'($urandom(32'h5eed_0776));
        d0 = $urandom_range(39, 1);

        // R1: reset
        repeat (3) @(posedge clk);
        #1;
        chk("R1 data_out", 64'(data_out), 0);
        chk("R1 slip", 64'(slip), 0);
        chk("R1 locked", 64'(locked), 0);
        chk("R1 lock_lost", 64'(lock_lost), 0);
        @(negedge clk) rst = 1'b0;

        // R2: disabled, misaligned
        d = d0;
        repeat (40) tick('0);
        chk("R2 slips", 64'(slips), 0);
        chk("R2 locked", 64'(locked), 0);
        chk("R2 lock_lost", 64'(lock_lost), 0);

        // R3/R4: acquisition from offset d0
        enable = 1'b1;
        acquire(n);
        chk("R4 slip count", 64'(n), 64'(d0));
        chk("R4 locked", 64'(locked), 1);
        chk("R4 offset", 64'(d), 0);

        // R5: random data while locked
        for (int k = 0; k < 300; k++) begin
            r = {$urandom(), $urandom()};
            tick(r);
        end
        for (int k = 0; k < 20; k++) tick('0);
        chk("R5 still locked", 64'(locked), 1);

        // R7: drift at the window limits
        d = 4;
        run_edges(70);
        chk("R7 +4 locked", 64'(locked), 1);
        chk("R7 +4 lock_lost", 64'(lock_lost), 0);
        d = -4;
        run_edges(70);
        chk("R7 -4 locked", 64'(locked), 1);
        chk("R7 -4 lock_lost", 64'(lock_lost), 0);
        d = 0;
        run_edges(2);

        // R11: a seen edge clears the miss count
        d = 5;
        run_edges(60);
        d = 0;
        run_edges(1);
        d = 5;
        run_edges(60);
        chk("R11 locked", 64'(locked), 1);
        chk("R11 lock_lost", 64'(lock_lost), 0);
        d = 0;
        run_edges(2);

        // R8/R9: loss after 61 misses, automatic re-hunt
        auto_reacq = 1'b1;
        d = 5;
        e = 0;
        while (e < 61) begin
            tick('0);
            if (cur_w % EDGE_WORDS == 0) begin
                e++;
                chk("R8 lock_lost at edge", 64'(lock_lost), 64'(e == 61));
                chk("R8 locked at edge", 64'(locked), 64'(e != 61));
            end
        end
        tick('0);
        chk("R9 pulse end", 64'(lock_lost), 0);
        acquire(n);
        chk("R9 reacq slips", 64'(n), 5);
        chk("R9 relocked", 64'(locked), 1);
        run_edges(2);

        // R10: halt until enable is cycled
        auto_reacq = 1'b0;
        d = 5;
        run_edges(61);
        chk("R10 lost", 64'(lock_lost), 1);
        n = slips;
        repeat (60) tick('0);
        chk("R10 held", 64'(lock_lost), 1);
        chk("R10 no slips", 64'(slips - n), 0);
        chk("R10 unlocked", 64'(locked), 0);
        enable = 1'b0;
        tick('0);
        chk("R10 cleared", 64'(lock_lost), 0);
        enable = 1'b1;
        acquire(n);
        chk("R10 reacq slips", 64'(n), 5);
        chk("R10 relocked", 64'(locked), 1);

        // R2 again: dropping enable while locked
        enable = 1'b0;
        tick('0);
        chk("R2 unlock", 64'(locked), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule